// File: doc/BRIEF.md
# Mask-Controlled Selective Load/Store Unit

This block performs the two bit-selective data moves of an accumulator datapath. A mask word decides, bit by bit, which positions are replaced. In a selective load, the masked positions of the accumulator take the incoming memory bits. In a selective store, the masked positions of the memory word take the accumulator bits. Every unmasked bit keeps its old value in both directions.

When the requester sets the condition-request bit, the block labels the result word in one of three ways: all ones, all zeros, or a mix. It does not compare the word with zero as a signed number. For a load, the result word is the new accumulator. For a store, it is the new memory word. In literal mode, a load uses an 18-bit operand taken from the low bits of the memory bus and sign-extends it before masking.

Results are registered and appear one clock after a one-cycle `op_start`. Address generation and memory sequencing belong to the surrounding pipeline.

Top module: `ssl_unit`

## Requirements
- R1: A load (`op_start`=1, `op_store`=0) sets `acc_out` on the next cycle to (`acc_a` AND NOT `mask_b`) OR (operand AND `mask_b`). When `lit_mode`=0, the operand is `mem_word`.
- R2: A store (`op_start`=1, `op_store`=1) sets `mem_out` on the next cycle to (`mem_word` AND NOT `mask_b`) OR (`acc_a` AND `mask_b`).
- R3: A load leaves `mem_we` low and `mem_out` unchanged. A store sets `acc_out` to the unmodified `acc_a`.
- R4: A store raises `mem_we` for exactly one cycle, in the same cycle that the merged word appears on `mem_out`.
- R5: With `cc_req`=1, `cc_code` on the next cycle classifies the result word as 1 (all ones), 2 (all zeros) or 3 (mixed), and `cc_valid` pulses for one cycle. The result word is `acc_out` for a load and `mem_out` for a store.
- R6: With `cc_req`=0, `cc_code` keeps its previous value and `cc_valid` stays low.
- R7: A load with `lit_mode`=1 takes `mem_word[17:0]` as the operand, copies bit 17 into bits 31..18, and then applies the mask. The other bits of `mem_word` have no effect.
- R8: An all-zero `mask_b` leaves the destination word equal to its old value. The classification of R5 is still produced.
- R9: After reset, `acc_out`, `mem_out` and `cc_code` are zero, and `mem_we` and `cc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_start | input | 1 | One-cycle request to execute an operation |
| op_store | input | 1 | 0 = selective load, 1 = selective store |
| cc_req | input | 1 | Request a condition classification of the result |
| lit_mode | input | 1 | Load operand is an 18-bit literal on mem_word[17:0] |
| mem_word | input | 32 | Memory word or literal operand |
| acc_a | input | 32 | Current accumulator value |
| mask_b | input | 32 | Bit mask; a 1 selects the position for replacement |
| acc_out | output | 32 | Accumulator value after the operation |
| mem_out | output | 32 | Merged memory word from the last store |
| mem_we | output | 1 | One-cycle memory write enable |
| cc_code | output | 2 | Condition indicator: 1 all ones, 2 all zeros, 3 mixed |
| cc_valid | output | 1 | Pulse marking a fresh cc_code |

## Verification
The assertions check the following on every cycle:
- the masked-merge equations for non-literal loads and for stores;
- the write-enable pulse: present only after a store, absent after a load;
- the hold of the condition code when no condition is requested;
- that a valid condition code is never zero;
- sign extension of literals under a full mask;
- the unchanged destination under an empty mask.

The directed scenarios are needed for the rest:
- the exact three-way classification values for chosen words;
- that the write enable drops again after one cycle;
- that upper bus bits are ignored in literal mode;
- the reset state.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef enum logic [1:0] {
    CC_NONE  = 2'd0,
    CC_ONES  = 2'd1,
    CC_ZEROS = 2'd2,
    CC_MIXED = 2'd3
  } cc_e;
endpackage

// File: rtl/ssl_operand_fmt.sv
module ssl_operand_fmt #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 18
) (
  input  logic              lit_mode,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] operand
);
  localparam int EXT_W = DATA_W - LIT_W;

  logic [LIT_W-1:0] lit_field;
  logic [EXT_W-1:0] ext_bits;

  assign lit_field = mem_word[LIT_W-1:0];
  assign ext_bits  = {EXT_W{lit_field[LIT_W-1]}};

  always_comb begin
    if (lit_mode) operand = {ext_bits, lit_field};
    else          operand = mem_word;
  end
endmodule

// File: rtl/ssl_bit_merge.sv
module ssl_bit_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic [W-1:0] merged
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign merged[i] = mask[i] ? src[i] : base[i];
  end
endmodule

// File: rtl/ssl_classify.sv
module ssl_classify #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  output logic [1:0]   code
);
  import ssl_pkg::*;
  logic all_ones, all_zeros;

  assign all_ones  = &word;
  assign all_zeros = ~|word;

  always_comb begin
    if (all_ones)       code = CC_ONES;
    else if (all_zeros) code = CC_ZEROS;
    else                code = CC_MIXED;
  end
endmodule

// File: rtl/ssl_unit.sv
module ssl_unit #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_store,
  input  logic              cc_req,
  input  logic              lit_mode,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] mask_b,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] mem_out,
  output logic              mem_we,
  output logic [1:0]        cc_code,
  output logic              cc_valid
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [DATA_W-1:0] ld_operand, ld_merged, st_merged, chk_word;
  logic [1:0]        class_code;

  ssl_operand_fmt #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_fmt (
    .lit_mode (lit_mode),
    .mem_word (mem_word),
    .operand  (ld_operand)
  );

  ssl_bit_merge #(.W(DATA_W)) u_ld_merge (
    .base   (acc_a),
    .src    (ld_operand),
    .mask   (mask_b),
    .merged (ld_merged)
  );

  ssl_bit_merge #(.W(DATA_W)) u_st_merge (
    .base   (mem_word),
    .src    (acc_a),
    .mask   (mask_b),
    .merged (st_merged)
  );

  assign chk_word = op_store ? st_merged : ld_merged;

  ssl_classify #(.W(DATA_W)) u_class (
    .word (chk_word),
    .code (class_code)
  );

  // next-state
  logic              acc_en, mem_en, cc_en;
  logic [DATA_W-1:0] acc_nxt, mem_nxt;
  logic              we_nxt, ccv_nxt;
  logic [1:0]        cc_nxt;

  always_comb begin
    acc_en  = op_start;
    mem_en  = op_start & op_store;
    cc_en   = op_start & cc_req;
    acc_nxt = op_store ? acc_a : ld_merged;
    mem_nxt = st_merged;
    cc_nxt  = class_code;
    we_nxt  = op_start & op_store;
    ccv_nxt = op_start & cc_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_out  <= '0;
      mem_out  <= '0;
      cc_code  <= '0;
      mem_we   <= 1'b0;
      cc_valid <= 1'b0;
    end else begin
      if (acc_en) acc_out <= acc_nxt;
      if (mem_en) mem_out <= mem_nxt;
      if (cc_en)  cc_code <= cc_nxt;
      mem_we   <= we_nxt;
      cc_valid <= ccv_nxt;
    end
  end
endmodule

// File: rtl/ssl_unit_chk.sv
module ssl_unit_chk #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 18
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              op_start,
  input logic              op_store,
  input logic              cc_req,
  input logic              lit_mode,
  input logic [DATA_W-1:0] mem_word,
  input logic [DATA_W-1:0] acc_a,
  input logic [DATA_W-1:0] mask_b,
  input logic [DATA_W-1:0] acc_out,
  input logic [DATA_W-1:0] mem_out,
  input logic              mem_we,
  input logic [1:0]        cc_code,
  input logic              cc_valid
);
  p_load_merge_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && !op_store && !lit_mode) |=>
      acc_out == (($past(acc_a) & ~$past(mask_b)) | ($past(mem_word) & $past(mask_b))));

  p_store_merge_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_store) |=>
      mem_out == (($past(mem_word) & ~$past(mask_b)) | ($past(acc_a) & $past(mask_b))));

  p_load_no_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && !op_store) |=> (!mem_we && $stable(mem_out)));

  p_store_acc_kept_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_store) |=> acc_out == $past(acc_a));

  p_store_write_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_store) |=> mem_we);

  p_write_origin_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_start && op_store) |=> !mem_we);

  p_cc_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cc_valid |-> cc_code != 2'd0);

  p_cc_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_start && cc_req) |=> ($stable(cc_code) && !cc_valid));

  p_lit_sext_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && !op_store && lit_mode && (&mask_b)) |=>
      acc_out == DATA_W'($signed($past(mem_word[LIT_W-1:0]))));

  p_zero_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && !op_store && mask_b == '0) |=> acc_out == $past(acc_a));

  p_zero_mask_store_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_store && mask_b == '0) |=> mem_out == $past(mem_word));
endmodule

bind ssl_unit ssl_unit_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_start   (op_start),
  .op_store   (op_store),
  .cc_req     (cc_req),
  .lit_mode   (lit_mode),
  .mem_word   (mem_word),
  .acc_a      (acc_a),
  .mask_b     (mask_b),
  .acc_out    (acc_out),
  .mem_out    (mem_out),
  .mem_we     (mem_we),
  .cc_code    (cc_code),
  .cc_valid   (cc_valid)
);

// File: tb/tb_ssl_unit.sv
`timescale 1ns/1ps
module tb_ssl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_start, op_store, cc_req, lit_mode;
  logic [31:0] mem_word, acc_a, mask_b;
  logic [31:0] acc_out, mem_out;
  logic        mem_we, cc_valid;
  logic [1:0]  cc_code;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ssl_unit dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_store(op_store),
    .cc_req(cc_req), .lit_mode(lit_mode), .mem_word(mem_word), .acc_a(acc_a),
    .mask_b(mask_b), .acc_out(acc_out), .mem_out(mem_out), .mem_we(mem_we),
    .cc_code(cc_code), .cc_valid(cc_valid)
  );

  function automatic logic [31:0] merge(input logic [31:0] base, src, mask);
    return (base & ~mask) | (src & mask);
  endfunction

  function automatic logic [1:0] classify(input logic [31:0] w);
    if (w == 32'hFFFF_FFFF) return 2'd1;
    if (w == 32'h0)         return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [31:0] sext18(input logic [31:0] w);
    return {{14{w[17]}}, w[17:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation; returns at the negedge after the capturing posedge
  task automatic run_op(input logic st, input logic c, input logic lit,
                        input logic [31:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_start = 1'b1; op_store = st; cc_req = c; lit_mode = lit;
    mem_word = m; acc_a = a; mask_b = b;
    @(negedge clk);
    op_start = 1'b0; cc_req = 1'b0; lit_mode = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    op_start = 0; op_store = 0; cc_req = 0; lit_mode = 0;
    mem_word = 0; acc_a = 0; mask_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 acc_out", acc_out, 32'h0);
    chk("R9 mem_out", mem_out, 32'h0);
    chk("R9 cc_code", {30'h0, cc_code}, 32'h0);
    chk("R9 mem_we/cc_valid", {30'h0, mem_we, cc_valid}, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] prev_mem;
    prev_mem = mem_out;
    run_op(0, 1, 0, 32'hAAAA_AAAA, 32'h1234_5678, 32'hFF00_FF00);
    chk("R1 load merge", acc_out, merge(32'h1234_5678, 32'hAAAA_AAAA, 32'hFF00_FF00));
    chk("R5 load mixed", {30'h0, cc_code}, 32'd3);
    chk("R5 cc_valid", {31'h0, cc_valid}, 32'd1);
    chk("R3 load no write", {31'h0, mem_we}, 32'd0);
    chk("R3 mem_out kept", mem_out, prev_mem);
    run_op(0, 1, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000);
    chk("R1 load fill", acc_out, 32'hFFFF_FFFF);
    chk("R5 load ones", {30'h0, cc_code}, {30'h0, classify(32'hFFFF_FFFF)});
    @(negedge clk);
    chk("R5 cc_valid one cycle", {31'h0, cc_valid}, 32'd0);
  endtask

  task automatic t_store();
    run_op(1, 1, 0, 32'h1111_2222, 32'hDEAD_BEEF, 32'h0000_FFFF);
    chk("R2 store merge", mem_out, merge(32'h1111_2222, 32'hDEAD_BEEF, 32'h0000_FFFF));
    chk("R3 store acc kept", acc_out, 32'hDEAD_BEEF);
    chk("R4 we high", {31'h0, mem_we}, 32'd1);
    chk("R5 store mixed", {30'h0, cc_code}, 32'd3);
    @(negedge clk);
    chk("R4 we one cycle", {31'h0, mem_we}, 32'd0);
    run_op(1, 1, 0, 32'h1234_5678, 32'h0, 32'hFFFF_FFFF);
    chk("R2 store clear", mem_out, 32'h0);
    chk("R5 store zeros", {30'h0, cc_code}, 32'd2);
  endtask

  task automatic t_literal();
    run_op(0, 1, 1, 32'h5552_0001, 32'h0, 32'hFFFF_FFFF);
    chk("R7 negative literal", acc_out, sext18(32'h5552_0001));
    chk("R7 negative literal value", acc_out, 32'hFFFE_0001);
    run_op(0, 1, 1, 32'hFFF0_1234, 32'hFFFF_FFFF, 32'hFFFF_0000);
    chk("R7 positive literal masked", acc_out, 32'h0000_FFFF);
    chk("R7 cc", {30'h0, cc_code}, 32'd3);
  endtask

  task automatic t_cc_hold();
    run_op(0, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
    chk("R5 ones before hold", {30'h0, cc_code}, 32'd1);
    run_op(0, 0, 0, 32'h0, 32'h0, 32'hFFFF_FFFF);
    chk("R6 acc updated", acc_out, 32'h0);
    chk("R6 cc held", {30'h0, cc_code}, 32'd1);
    chk("R6 no valid", {31'h0, cc_valid}, 32'd0);
  endtask

  task automatic t_zero_mask();
    run_op(0, 1, 0, 32'hFFFF_FFFF, 32'h0, 32'h0);
    chk("R8 load kept", acc_out, 32'h0);
    chk("R8 load cc", {30'h0, cc_code}, 32'd2);
    chk("R8 load valid", {31'h0, cc_valid}, 32'd1);
    run_op(1, 1, 0, 32'hFFFF_FFFF, 32'h0, 32'h0);
    chk("R8 store kept", mem_out, 32'hFFFF_FFFF);
    chk("R8 store cc", {30'h0, cc_code}, 32'd1);
    chk("R8 store we", {31'h0, mem_we}, 32'd1);
  endtask

  initial begin
    #200_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_literal();
    t_cc_hold();
    t_zero_mask();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule